// File: doc/BRIEF.md
# NAND Flash Command Interface Target

This block is a synthesizable model of the device side of a small NAND flash part. A controller under test connects to it through the usual NAND pins. The pins are chip enable, command latch, address latch, write strobe and read strobe, together with an 8-bit data bus and a ready/busy line. The model samples these pins with its own clock and tells commands, addresses and data apart. It holds a scaled-down array of pages in registers. It answers with page data, a status byte or identification bytes.

Operations follow the two-step discipline that NAND parts use. A setup command is followed by address cycles, and nothing is launched until the matching confirm command arrives. Page loads, programs and erases each hold the ready/busy line low for a fixed number of clocks, set by a parameter. Blocks listed in a parameter mask behave as worn-out blocks. Any program or erase aimed at such a block reports a failure and leaves its contents alone.

Top module: `nfc_device`

## Requirements
- R1: After reset the model is in read mode: four address cycles followed by command 30h launch a page load without any 00h command before them.
- R2: A page load starts only on command 30h after four address cycles (column low, column high, row low, row high). After the load, each read strobe returns the next byte of the loaded page, beginning at the latched column and wrapping within the page.
- R3: An erase runs only when D0h directly follows 60h and its two row cycles, and it clears every byte of the addressed block to FFh. Any other command after 60h cancels it, and a later D0h then starts nothing.
- R4: rb_n is high when idle. It goes low on an accepted 30h, 10h or D0h confirm, stays low for exactly BUSY_CYC clocks, and then returns high.
- R5: Command 90h followed by address 00h enters identification mode. The next four reads return ECh, DEV_CODE, 00h and ID4. ID4 holds page size code in bits 1:0, spare size in bit 2, block size code in bits 5:4 and bus width in bit 6; by default it is 15h.
- R6: Identification mode and status mode persist until another command is written: a fifth ID read returns ECh again, and repeated status reads repeat the status byte.
- R7: A program cycle may load any run of consecutive bytes, starting at the latched column. Bytes that are not written keep their stored value.
- R8: While ce_n is high, write strobes are ignored, read strobes neither drive io nor advance the column, and the operation in progress continues when ce_n returns low.
- R9: The status byte carries ready in bit 6 (1 = ready) and fail in bit 0, with the other bits 0. While busy, only 70h is accepted, and every other command is ignored.
- R10: A program or erase aimed at a block flagged in BAD_BLKS sets the fail bit and leaves the block unchanged. A later successful operation clears the fail bit.
- R11: A program can only clear bits: the stored byte becomes the old value AND the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock of the model |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on its rising edge |
| re_n | input | 1 | Read strobe, data advances on its falling edge |
| io_in | input | 8 | Bus value driven by the controller |
| io_out | output | 8 | Byte presented by the model |
| io_oe | output | 1 | Model drives io_out while high |
| rb_n | output | 1 | Ready (high) / busy (low) |

## Verification
The hardest situation to reach is a command that arrives in the middle of a busy period. The bench must issue the status command and then a program setup inside the BUSY_CYC window of a page load. It does this by starting those writes right after the 30h confirm, before it waits for rb_n, so both land while the line is low. It reads back a busy status, and after the busy period a ready status, which shows that the setup was dropped. A cancelled erase is reached by putting a status command between 60h and D0h, and then checking that rb_n never falls and the page data survives.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam logic [7:0] OP_RD_SETUP = 8'h00;
  localparam logic [7:0] OP_RD_GO    = 8'h30;
  localparam logic [7:0] OP_PG_SETUP = 8'h80;
  localparam logic [7:0] OP_PG_GO    = 8'h10;
  localparam logic [7:0] OP_ER_SETUP = 8'h60;
  localparam logic [7:0] OP_ER_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] MAKER_CODE  = 8'hEC;

  typedef enum logic [2:0] {
    MD_READ, MD_PROG, MD_ERASE, MD_IDADR, MD_IDENT, MD_STAT
  } mode_e;

  typedef enum logic [1:0] {JOB_NONE, JOB_LOAD, JOB_PROG, JOB_ERASE} job_e;

  // fourth identification byte; field positions are decoded by hosts
  function automatic logic [7:0] id4_byte(input logic [1:0] pg_code,
                                          input logic       spare16,
                                          input logic [1:0] blk_code,
                                          input logic       wide,
                                          input logic       fast);
    id4_byte = {1'b0, wide, blk_code, fast, spare16, pg_code};
  endfunction
endpackage

// File: rtl/nfc_pin_sync.sv
module nfc_pin_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic       cmd_we,
  output logic       adr_we,
  output logic       dat_we,
  output logic       rd_fall,
  output logic [7:0] io_s
);
  // bit map: 12 ce_n, 11 cle, 10 ale, 9 we_n, 8 re_n, 7:0 bus
  localparam logic [12:0] PIN_IDLE = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};

  logic [12:0] s1_q, s2_q;
  logic        we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= PIN_IDLE;
      s2_q <= PIN_IDLE;
    end else begin
      s1_q <= {ce_n, cle, ale, we_n, re_n, io_in};
      s2_q <= s1_q;
    end
  end

  assign we_rise = s1_q[9] & ~s2_q[9] & ~s2_q[12];
  assign cmd_we  = we_rise & s2_q[11] & ~s2_q[10];
  assign adr_we  = we_rise & s2_q[10] & ~s2_q[11];
  assign dat_we  = we_rise & (s2_q[11] == s2_q[10]);
  assign rd_fall = ~s1_q[8] & s2_q[8] & ~s1_q[12];
  assign io_s    = s2_q[7:0];
endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
  parameter int BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(BUSY_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int PAGE_BYTES    = 8,
  parameter int NUM_PAGES     = 16,
  parameter int PAGES_PER_BLK = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [$clog2(NUM_PAGES)-1:0]           rd_row,
  output logic [PAGE_BYTES-1:0][7:0]             rd_page,
  input  logic                                   prog_en,
  input  logic [$clog2(NUM_PAGES)-1:0]           prog_row,
  input  logic [PAGE_BYTES-1:0][7:0]             prog_page,
  input  logic                                   erase_en,
  input  logic [$clog2(NUM_PAGES/PAGES_PER_BLK)-1:0] erase_blk
);
  localparam int ROW_W = $clog2(NUM_PAGES);
  localparam int BLK_W = $clog2(NUM_PAGES / PAGES_PER_BLK);

  logic [PAGE_BYTES-1:0][7:0] mem_q [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[p] <= '1;
      else if (prog_en && (prog_row == ROW_W'(p)))
        mem_q[p] <= mem_q[p] & prog_page;
      else if (erase_en && (erase_blk == BLK_W'(p / PAGES_PER_BLK)))
        mem_q[p] <= '1;
    end
  end

  assign rd_page = mem_q[rd_row];
endmodule

// File: rtl/nfc_device.sv
module nfc_device
  import nfc_pkg::*;
#(
  parameter int          PAGE_BYTES    = 8,
  parameter int          PAGES_PER_BLK = 4,
  parameter int          NUM_BLKS      = 4,
  parameter int          BUSY_CYC      = 20,
  parameter logic [NUM_BLKS-1:0] BAD_BLKS = NUM_BLKS'(4),
  parameter logic [7:0]  DEV_CODE      = 8'hA1,
  parameter logic [7:0]  ID4           = nfc_pkg::id4_byte(2'b01, 1'b1, 2'b01, 1'b0, 1'b0)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n
);
  localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
  localparam int COL_W     = $clog2(PAGE_BYTES);
  localparam int ROW_W     = $clog2(NUM_PAGES);
  localparam int PG_W      = $clog2(PAGES_PER_BLK);
  localparam int BLK_W     = ROW_W - PG_W;

  logic       cmd_we, adr_we, dat_we, rd_fall;
  logic [7:0] io_s;
  logic       busy, job_done, go;

  mode_e                      mode_q, mode_d;
  job_e                       job_q, job_d;
  logic [2:0]                 acnt_q, acnt_d;
  logic [COL_W-1:0]           col_q, col_d;
  logic [ROW_W-1:0]           row_q, row_d;
  logic [1:0]                 idx_q, idx_d;
  logic                       fail_q, fail_d;
  logic [7:0]                 dout_q, dout_d;
  logic [PAGE_BYTES-1:0][7:0] buf_q, buf_d, arr_page;
  logic [BLK_W-1:0]           blk_idx;
  logic                       blk_bad;
  logic [7:0]                 status, id_byte;

  nfc_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .cmd_we(cmd_we),
    .adr_we(adr_we), .dat_we(dat_we), .rd_fall(rd_fall), .io_s(io_s)
  );

  nfc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go), .busy(busy), .done(job_done)
  );

  assign blk_idx = row_q[ROW_W-1:PG_W];
  assign blk_bad = BAD_BLKS[blk_idx];

  nfc_array #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PAGES_PER_BLK(PAGES_PER_BLK)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .rd_row(row_q), .rd_page(arr_page),
    .prog_en(job_done && (job_q == JOB_PROG) && !blk_bad),
    .prog_row(row_q), .prog_page(buf_q),
    .erase_en(job_done && (job_q == JOB_ERASE) && !blk_bad),
    .erase_blk(blk_idx)
  );

  assign status = {1'b0, ~busy, 5'b00000, fail_q};

  always_comb begin
    case (idx_q)
      2'd0:    id_byte = MAKER_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = 8'h00;
      default: id_byte = ID4;
    endcase
  end

  always_comb begin
    mode_d = mode_q; job_d = job_q; acnt_d = acnt_q; col_d = col_q;
    row_d  = row_q;  idx_d = idx_q; fail_d = fail_q; dout_d = dout_q;
    buf_d  = buf_q;  go    = 1'b0;

    if (job_done) begin
      case (job_q)
        JOB_LOAD:  begin buf_d = arr_page; fail_d = 1'b0; end
        JOB_PROG:  fail_d = blk_bad;
        JOB_ERASE: fail_d = blk_bad;
        default:   ;
      endcase
      job_d = JOB_NONE;
    end

    if (cmd_we && (!busy || io_s == OP_STATUS)) begin
      acnt_d = '0;
      case (io_s)
        OP_RD_SETUP: mode_d = MD_READ;
        OP_RD_GO: begin
          mode_d = MD_READ;
          if (mode_q == MD_READ && acnt_q == 3'd4) begin go = 1'b1; job_d = JOB_LOAD; end
        end
        OP_PG_SETUP: begin mode_d = MD_PROG; buf_d = '1; end
        OP_PG_GO: begin
          mode_d = MD_READ;
          if (mode_q == MD_PROG && acnt_q == 3'd4) begin
            go = 1'b1; job_d = JOB_PROG; mode_d = MD_STAT;
          end
        end
        OP_ER_SETUP: mode_d = MD_ERASE;
        OP_ER_GO: begin
          mode_d = MD_READ;
          if (mode_q == MD_ERASE && acnt_q == 3'd2) begin
            go = 1'b1; job_d = JOB_ERASE; mode_d = MD_STAT;
          end
        end
        OP_STATUS: mode_d = MD_STAT;
        OP_IDENT:  mode_d = MD_IDADR;
        default:   mode_d = MD_READ;
      endcase
    end else if (adr_we && !busy) begin
      case (mode_q)
        MD_READ, MD_PROG: begin
          if (acnt_q == 3'd0) col_d = io_s[COL_W-1:0];
          if (acnt_q == 3'd2) row_d = io_s[ROW_W-1:0];
          if (acnt_q != 3'd4) acnt_d = acnt_q + 3'd1;
        end
        MD_ERASE: begin
          if (acnt_q == 3'd0) row_d = io_s[ROW_W-1:0];
          if (acnt_q != 3'd2) acnt_d = acnt_q + 3'd1;
        end
        MD_IDADR: begin
          if (io_s == 8'h00) begin mode_d = MD_IDENT; idx_d = '0; end
          else               mode_d = MD_READ;
        end
        default: ;
      endcase
    end else if (dat_we && !busy && mode_q == MD_PROG && acnt_q == 3'd4) begin
      buf_d[col_q] = io_s;
      col_d        = col_q + 1'b1;
    end

    if (rd_fall) begin
      case (mode_q)
        MD_READ:  begin dout_d = buf_q[col_q]; col_d = col_q + 1'b1; end
        MD_STAT:  dout_d = status;
        MD_IDENT: begin dout_d = id_byte; idx_d = idx_q + 1'b1; end
        default:  dout_d = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;  job_q  <= JOB_NONE; acnt_q <= '0;
      col_q  <= '0;       row_q  <= '0;       idx_q  <= '0;
      fail_q <= 1'b0;     dout_q <= '0;       buf_q  <= '1;
    end else begin
      mode_q <= mode_d;   job_q  <= job_d;    acnt_q <= acnt_d;
      col_q  <= col_d;    row_q  <= row_d;    idx_q  <= idx_d;
      fail_q <= fail_d;   dout_q <= dout_d;   buf_q  <= buf_d;
    end
  end

  assign io_out = dout_q;
  assign io_oe  = ~ce_n & ~re_n;
  assign rb_n   = ~busy;
endmodule

// File: rtl/nfc_device_chk.sv
module nfc_device_chk
  import nfc_pkg::*;
#(
  parameter int BUSY_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rb_n,
  input logic       cmd_we,
  input logic [7:0] io_s,
  input logic       rd_fall,
  input mode_e      mode_q,
  input logic [1:0] idx_q,
  input logic [7:0] io_out,
  input logic       job_done,
  input logic       fail_q
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= 0;
    else if (rb_n) low_cnt <= 0;
    else           low_cnt <= low_cnt + 1;
  end

  AST_BUSY_FROM_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> $past(cmd_we && (io_s == OP_RD_GO || io_s == OP_PG_GO || io_s == OP_ER_GO))); // R4

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_n) |-> (low_cnt == BUSY_CYC)); // R4

  AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !job_done |=> $stable(fail_q)); // R10

  AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && mode_q == MD_IDENT && idx_q == 2'd0) |=> (io_out == MAKER_CODE)); // R5

  AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && mode_q == MD_STAT) |=> (io_out[6] == $past(rb_n))); // R9
endmodule

bind nfc_device nfc_device_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .cmd_we(cmd_we), .io_s(io_s),
  .rd_fall(rd_fall), .mode_q(mode_q), .idx_q(idx_q), .io_out(io_out),
  .job_done(job_done), .fail_q(fail_q)
);

// File: tb/sim_nfc_device.sv
module sim_nfc_device;
  localparam int BUSY = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       cle = 1'b0;
  logic       ale = 1'b0;
  logic       we_n = 1'b1;
  logic       re_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic       io_oe, rb_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  nfc_device #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  wr(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  wr(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  wr(1'b0, 1'b0, d); endtask

  task automatic addr4(input logic [7:0] col, input logic [7:0] row);
    adr(col); adr(8'h00); adr(row); adr(8'h00);
  endtask

  task automatic wait_ready(output int lows);
    int t = 0;
    lows = 0;
    while (rb_n && t < 10) begin @(negedge clk); t++; end
    while (!rb_n && lows < 1000) begin lows++; @(negedge clk); end
  endtask

  // driver: push the expected byte, then strobe
  task automatic rd(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk); re_n = 1'b0;
    repeat (2) @(negedge clk);
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_page(input logic [7:0] col, input logic [7:0] row);
    int l;
    cmd(8'h00); addr4(col, row); cmd(8'h30); wait_ready(l);
  endtask

  // monitor: compare each byte as the read strobe is released
  always @(posedge re_n) begin
    if (!ce_n && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string r = tag_q.pop_front();
      check(io_out == e, r, io_out, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int l;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ce_n  = 1'b0;
    @(negedge clk);
    check(rb_n == 1'b1, "R4 idle", rb_n, 1);
    check(io_oe == 1'b0, "R8 oe idle", io_oe, 0);

    // R1: read without a setup command right after reset
    addr4(8'h00, 8'h00); cmd(8'h30); wait_ready(l);
    check(l == BUSY, "R1 busy", l, BUSY);
    rd(8'hFF, "R1");

    // R7: partial program of page 1, columns 2..5
    cmd(8'h80); addr4(8'h02, 8'h01);
    dat(8'hA5); dat(8'h3C); dat(8'h0F); dat(8'hF0);
    cmd(8'h10); wait_ready(l);
    check(l == BUSY, "R4 program busy", l, BUSY);
    cmd(8'h70); rd(8'h40, "R9 pass");

    // R2: sequential output from column 1
    load_page(8'h01, 8'h01);
    rd(8'hFF, "R2"); rd(8'hA5, "R2"); rd(8'h3C, "R2");
    rd(8'h0F, "R2"); rd(8'hF0, "R7"); rd(8'hFF, "R7");

    // R11: AND with stored data
    cmd(8'h80); addr4(8'h02, 8'h01); dat(8'hF0); cmd(8'h10); wait_ready(l);
    load_page(8'h02, 8'h01);
    rd(8'hA0, "R11"); rd(8'h3C, "R7 untouched");

    // R3: erase cancelled by another command
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'h70); cmd(8'hD0);
    repeat (5) @(negedge clk);
    check(rb_n == 1'b1, "R3 cancelled", rb_n, 1);
    load_page(8'h02, 8'h01);
    rd(8'hA0, "R3 kept");

    // R3: proper erase
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0); wait_ready(l);
    check(l == BUSY, "R3 erase busy", l, BUSY);
    cmd(8'h70); rd(8'h40, "R9 erase pass");
    load_page(8'h02, 8'h01);
    rd(8'hFF, "R3 erased");

    // R10: flagged block 2 (pages 8..11)
    cmd(8'h80); addr4(8'h00, 8'h08); dat(8'h00); cmd(8'h10); wait_ready(l);
    cmd(8'h70); rd(8'h41, "R10 program fail");
    load_page(8'h00, 8'h08);
    rd(8'hFF, "R10 unchanged");
    cmd(8'h60); adr(8'h08); adr(8'h00); cmd(8'hD0); wait_ready(l);
    cmd(8'h70); rd(8'h41, "R10 erase fail");
    cmd(8'h80); addr4(8'h00, 8'h04); dat(8'h5A); cmd(8'h10); wait_ready(l);
    cmd(8'h70); rd(8'h40, "R10 fail cleared");

    // R5 / R6: identification
    cmd(8'h90); adr(8'h00);
    rd(8'hEC, "R5"); rd(8'hA1, "R5"); rd(8'h00, "R5"); rd(8'h15, "R5");
    rd(8'hEC, "R6 id stays");
    cmd(8'h70); rd(8'h40, "R6"); rd(8'h40, "R6 status stays");

    // R8: chip enable high during loading and output
    cmd(8'h80); addr4(8'h00, 8'h05); dat(8'h11);
    ce_n = 1'b1; dat(8'h22); ce_n = 1'b0;
    dat(8'h33); cmd(8'h10); wait_ready(l);
    load_page(8'h00, 8'h05);
    rd(8'h11, "R8");
    ce_n = 1'b1;
    @(negedge clk); re_n = 1'b0;
    repeat (2) @(negedge clk);
    check(io_oe == 1'b0, "R8 no drive", io_oe, 0);
    re_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    rd(8'h33, "R8"); rd(8'hFF, "R8");

    // R9: commands while busy
    cmd(8'h00); addr4(8'h00, 8'h04); cmd(8'h30);
    cmd(8'h70); rd(8'h00, "R9 busy status");
    cmd(8'h80);
    wait_ready(l);
    rd(8'h40, "R9 setup ignored");
    cmd(8'h00); rd(8'h5A, "R2 loaded");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
    finish_up();
  end
endmodule